// File: doc/BRIEF.md
# Dual-Operand Effective Address Generator

This block turns the addressing fields of one two-operand operation into a source and a destination memory address for a 16-bit datapath. Each operand carries its own 4-bit mode code and its own pointer register index. Both operands share one offset-register index, one 16-bit literal and one byte/word size flag. The block drives three read-port addresses into an external 16-entry working register file. It takes the read data back in the same cycle. On the clock edge where `in_valid` is high, it registers both addresses, a per-operand flag that says whether a memory address was produced, and the pointer writeback requests that the chosen modes imply.

The mode codes are: 0 register operand (no memory address); 1 absolute address taken from the literal; 2 pointer indirect; 3 post-increment; 4 post-decrement; 5 pre-increment; 6 pre-decrement; 7 pointer plus offset register; 8 pointer plus literal. Codes 9 to 15 behave like code 0. Both addresses are computed from the register contents as they stand before any update of this operation.

When both operands modify the same register, the two updates are folded into one destination-side writeback, and the destination step is applied last. The surrounding pipeline owns the register file, decodes the operation and performs the memory accesses.

Top module: `ea_pair_gen`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `src_wb_en` and `dst_wb_en` are 0 after the next clock edge.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Neither writeback enable is ever high while `out_valid` is low.
- R3: Mode 0 and the unused codes 9 to 15 give an address-valid flag of 0 and no writeback for that operand.
- R4: Mode 1 gives the literal as the address, with the flag set and no writeback.
- R5: Mode 2 gives the pointer register value as the address and issues no writeback.
- R6: Modes 3 and 4 give the unmodified pointer value as the address. They write back the pointer plus the step (mode 3) or minus the step (mode 4) to the same register index.
- R7: Modes 5 and 6 write back the pointer plus the step (mode 5) or minus the step (mode 6). The address equals that new value.
- R8: The step is 1 when `byte_op` is 1 and 2 when it is 0. All address and pointer arithmetic wraps modulo 2^16.
- R9: Mode 7 gives the pointer plus the register selected by `ofs_idx`. Both operands use the same offset register.
- R10: Mode 8 gives the pointer plus the literal.
- R11: Source and destination modes are chosen independently, and each operand's result depends only on its own mode and pointer.
- R12: When both operands modify the same register index, `src_wb_en` stays 0. `dst_wb_en` carries that index with the original value plus the source step plus the destination step.
- R13: The read-port addresses follow `src_idx`, `dst_idx` and `ofs_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| src_mode | input | 4 | Source addressing mode code |
| src_idx | input | 4 | Source pointer register index |
| dst_mode | input | 4 | Destination addressing mode code |
| dst_idx | input | 4 | Destination pointer register index |
| ofs_idx | input | 4 | Shared offset register index |
| lit | input | 16 | Shared literal / absolute address |
| byte_op | input | 1 | 1 = byte operation, 0 = word |
| rd_src_addr | output | 4 | Register file read address, source pointer |
| rd_dst_addr | output | 4 | Register file read address, destination pointer |
| rd_ofs_addr | output | 4 | Register file read address, offset register |
| rd_src_data | input | 16 | Source pointer read data |
| rd_dst_data | input | 16 | Destination pointer read data |
| rd_ofs_data | input | 16 | Offset register read data |
| out_valid | output | 1 | Registered results valid |
| src_ea | output | 16 | Source effective address |
| src_ea_valid | output | 1 | Source produced a memory address |
| dst_ea | output | 16 | Destination effective address |
| dst_ea_valid | output | 1 | Destination produced a memory address |
| src_wb_en | output | 1 | Source pointer writeback request |
| src_wb_idx | output | 4 | Source writeback register index |
| src_wb_data | output | 16 | Source writeback value |
| dst_wb_en | output | 1 | Destination pointer writeback request |
| dst_wb_idx | output | 4 | Destination writeback register index |
| dst_wb_data | output | 16 | Destination writeback value |

## Verification
The assertions assume the read data answer the read addresses within the same cycle. They also assume the mode, index and literal inputs are stable from the driving half-cycle through the capturing edge. The pre-modify check is conditioned on distinct source and destination indices, because a shared modified register moves the writeback to the destination side. The bench keeps a fixed register file model that answers the read ports combinationally. It changes its inputs only on falling edges, and it covers shared-index operations with directed cases before a sequence of mixed operations drawn from a linear feedback register.

// File: rtl/ea_pkg.sv
// Package ea_pkg
// Holds the addressing mode codes shared by the generator, its
// operand units and the checker. Assumes a 4-bit mode field.
package ea_pkg;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        AM_REG     = 4'd0,
        AM_ABS     = 4'd1,
        AM_IND     = 4'd2,
        AM_POSTINC = 4'd3,
        AM_POSTDEC = 4'd4,
        AM_PREINC  = 4'd5,
        AM_PREDEC  = 4'd6,
        AM_INDEX   = 4'd7,
        AM_LITOFS  = 4'd8
    } am_t;
endpackage

// File: rtl/ea_operand_unit.sv
// Module ea_operand_unit
// Combinational address computation for one operand. Given the mode,
// pointer value, offset register value, literal and size flag it returns
// the address, whether it is a memory address, whether the pointer is
// updated, and the signed step (as a wrapped addend). Assumes DATA_W is a
// multiple of 8; the word step is DATA_W/8 bytes.
module ea_operand_unit #(
    parameter int DATA_W = 16
) (
    input  logic [ea_pkg::MODE_W-1:0] mode,
    input  logic [DATA_W-1:0]         base,
    input  logic [DATA_W-1:0]         ofs,
    input  logic [DATA_W-1:0]         lit,
    input  logic                      byte_op,
    output logic [DATA_W-1:0]         ea,
    output logic                      ea_valid,
    output logic                      ptr_wr,
    output logic [DATA_W-1:0]         delta,
    output logic [DATA_W-1:0]         new_ptr
);
    import ea_pkg::*;

    localparam int              WORD_BYTES = DATA_W / 8;
    localparam logic [DATA_W-1:0] STEP_BYTE = DATA_W'(1);
    localparam logic [DATA_W-1:0] STEP_WORD = DATA_W'(WORD_BYTES);

    logic [DATA_W-1:0] step;

    // Select the step size and its signed form for the current mode.
    always_comb begin
        step  = byte_op ? STEP_BYTE : STEP_WORD;
        delta = '0;
        case (am_t'(mode))
            AM_POSTINC, AM_PREINC: delta = step;
            AM_POSTDEC, AM_PREDEC: delta = DATA_W'(0) - step;
            default:               delta = '0;
        endcase
        new_ptr = base + delta;
    end

    // Form the effective address and the flags for the current mode.
    always_comb begin
        ea       = '0;
        ea_valid = 1'b1;
        ptr_wr   = 1'b0;
        case (am_t'(mode))
            AM_ABS:                ea = lit;
            AM_IND:                ea = base;
            AM_POSTINC, AM_POSTDEC: begin
                ea     = base;
                ptr_wr = 1'b1;
            end
            AM_PREINC, AM_PREDEC: begin
                ea     = new_ptr;
                ptr_wr = 1'b1;
            end
            AM_INDEX:              ea = base + ofs;
            AM_LITOFS:             ea = base + lit;
            default:               ea_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/ea_wb_merge.sv
// Module ea_wb_merge
// Resolves pointer writebacks of the two operands. When both update the
// same register, the source request is dropped and the destination
// request carries the sum of both steps (destination applied last).
// Assumes both operands read the same pre-update value of that register.
module ea_wb_merge #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              s_wr,
    input  logic [IDX_W-1:0]  s_idx,
    input  logic [DATA_W-1:0] s_new,
    input  logic [DATA_W-1:0] s_delta,
    input  logic              d_wr,
    input  logic [IDX_W-1:0]  d_idx,
    input  logic [DATA_W-1:0] d_new,
    output logic              s_en,
    output logic              d_en,
    output logic [DATA_W-1:0] s_data,
    output logic [DATA_W-1:0] d_data
);
    logic clash;

    // Detect a shared modified register and fold the updates together.
    always_comb begin
        clash  = s_wr && d_wr && (s_idx == d_idx);
        s_en   = s_wr && !clash;
        d_en   = d_wr;
        s_data = s_new;
        d_data = clash ? (d_new + s_delta) : d_new;
    end
endmodule

// File: rtl/ea_pair_gen.sv
// Module ea_pair_gen
// Top level of the dual-operand effective address generator. Drives the
// register file read ports from the operand fields, runs one operand
// unit per operand, merges the pointer writebacks and registers all
// results one cycle after in_valid. Assumes the register file answers
// reads combinationally within the same cycle.
module ea_pair_gen #(
    parameter int DATA_W = 16,
    parameter int REG_N  = 16,
    parameter int IDX_W  = $clog2(REG_N)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [ea_pkg::MODE_W-1:0] src_mode,
    input  logic [IDX_W-1:0]          src_idx,
    input  logic [ea_pkg::MODE_W-1:0] dst_mode,
    input  logic [IDX_W-1:0]          dst_idx,
    input  logic [IDX_W-1:0]          ofs_idx,
    input  logic [DATA_W-1:0]         lit,
    input  logic                      byte_op,
    output logic [IDX_W-1:0]          rd_src_addr,
    output logic [IDX_W-1:0]          rd_dst_addr,
    output logic [IDX_W-1:0]          rd_ofs_addr,
    input  logic [DATA_W-1:0]         rd_src_data,
    input  logic [DATA_W-1:0]         rd_dst_data,
    input  logic [DATA_W-1:0]         rd_ofs_data,
    output logic                      out_valid,
    output logic [DATA_W-1:0]         src_ea,
    output logic                      src_ea_valid,
    output logic [DATA_W-1:0]         dst_ea,
    output logic                      dst_ea_valid,
    output logic                      src_wb_en,
    output logic [IDX_W-1:0]          src_wb_idx,
    output logic [DATA_W-1:0]         src_wb_data,
    output logic                      dst_wb_en,
    output logic [IDX_W-1:0]          dst_wb_idx,
    output logic [DATA_W-1:0]         dst_wb_data
);
    localparam int NOPS = 2;
    localparam int SRC  = 0;
    localparam int DST  = 1;

    logic [NOPS-1:0][ea_pkg::MODE_W-1:0] op_mode;
    logic [NOPS-1:0][DATA_W-1:0]         op_base;
    logic [NOPS-1:0][DATA_W-1:0]         op_ea;
    logic [NOPS-1:0]                     op_eav;
    logic [NOPS-1:0]                     op_wr;
    logic [NOPS-1:0][DATA_W-1:0]         op_delta;
    logic [NOPS-1:0][DATA_W-1:0]         op_new;

    logic              m_s_en, m_d_en;
    logic [DATA_W-1:0] m_s_data, m_d_data;

    // Route operand fields to the register file read ports.
    always_comb begin
        rd_src_addr  = src_idx;
        rd_dst_addr  = dst_idx;
        rd_ofs_addr  = ofs_idx;
        op_mode[SRC] = src_mode;
        op_mode[DST] = dst_mode;
        op_base[SRC] = rd_src_data;
        op_base[DST] = rd_dst_data;
    end

    // One address unit per operand; both share offset, literal and size.
    for (genvar g = 0; g < NOPS; g++) begin : g_op
        ea_operand_unit #(.DATA_W(DATA_W)) u_unit (
            .mode     (op_mode[g]),
            .base     (op_base[g]),
            .ofs      (rd_ofs_data),
            .lit      (lit),
            .byte_op  (byte_op),
            .ea       (op_ea[g]),
            .ea_valid (op_eav[g]),
            .ptr_wr   (op_wr[g]),
            .delta    (op_delta[g]),
            .new_ptr  (op_new[g])
        );
    end

    ea_wb_merge #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_merge (
        .s_wr    (op_wr[SRC]),
        .s_idx   (src_idx),
        .s_new   (op_new[SRC]),
        .s_delta (op_delta[SRC]),
        .d_wr    (op_wr[DST]),
        .d_idx   (dst_idx),
        .d_new   (op_new[DST]),
        .s_en    (m_s_en),
        .d_en    (m_d_en),
        .s_data  (m_s_data),
        .d_data  (m_d_data)
    );

    // Register the strobe and writeback enables; cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            src_wb_en <= 1'b0;
            dst_wb_en <= 1'b0;
        end else begin
            out_valid <= in_valid;
            src_wb_en <= in_valid && m_s_en;
            dst_wb_en <= in_valid && m_d_en;
        end
    end

    // Capture the address pair and writeback payloads on each operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_ea       <= '0;
            src_ea_valid <= 1'b0;
            dst_ea       <= '0;
            dst_ea_valid <= 1'b0;
            src_wb_idx   <= '0;
            src_wb_data  <= '0;
            dst_wb_idx   <= '0;
            dst_wb_data  <= '0;
        end else if (in_valid) begin
            src_ea       <= op_ea[SRC];
            src_ea_valid <= op_eav[SRC];
            dst_ea       <= op_ea[DST];
            dst_ea_valid <= op_eav[DST];
            src_wb_idx   <= src_idx;
            src_wb_data  <= m_s_data;
            dst_wb_idx   <= dst_idx;
            dst_wb_data  <= m_d_data;
        end
    end
endmodule

// File: rtl/ea_pair_gen_chk.sv
// Module ea_pair_gen_chk
// Property checker for ea_pair_gen, attached by bind. Assumes read data
// answer the read addresses in the same cycle.
module ea_pair_gen_chk #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [ea_pkg::MODE_W-1:0] src_mode,
    input logic [IDX_W-1:0]          src_idx,
    input logic [IDX_W-1:0]          dst_idx,
    input logic [DATA_W-1:0]         lit,
    input logic [DATA_W-1:0]         rd_src_data,
    input logic                      out_valid,
    input logic [DATA_W-1:0]         src_ea,
    input logic                      src_ea_valid,
    input logic                      src_wb_en,
    input logic [IDX_W-1:0]          src_wb_idx,
    input logic [DATA_W-1:0]         src_wb_data,
    input logic                      dst_wb_en,
    input logic [IDX_W-1:0]          dst_wb_idx
);
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_wb_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_wb_en || dst_wb_en) |-> out_valid);
    p_reg_no_ea_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_mode == ea_pkg::AM_REG) |=> (!src_ea_valid && !src_wb_en));
    p_abs_lit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_mode == ea_pkg::AM_ABS) |=> (src_ea == $past(lit) && src_ea_valid));
    p_ind_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_mode == ea_pkg::AM_IND) |=> (src_ea == $past(rd_src_data) && !src_wb_en));
    p_pre_ea_eq_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (src_mode == ea_pkg::AM_PREINC || src_mode == ea_pkg::AM_PREDEC)
         && src_idx != dst_idx) |=> (src_wb_en && src_ea == src_wb_data));
    p_single_wb_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (src_wb_en && dst_wb_en) |-> (src_wb_idx != dst_wb_idx));
endmodule

bind ea_pair_gen ea_pair_gen_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .src_mode     (src_mode),
    .src_idx      (src_idx),
    .dst_idx      (dst_idx),
    .lit          (lit),
    .rd_src_data  (rd_src_data),
    .out_valid    (out_valid),
    .src_ea       (src_ea),
    .src_ea_valid (src_ea_valid),
    .src_wb_en    (src_wb_en),
    .src_wb_idx   (src_wb_idx),
    .src_wb_data  (src_wb_data),
    .dst_wb_en    (dst_wb_en),
    .dst_wb_idx   (dst_wb_idx)
);

// File: tb/ea_pair_gen_bench.sv
// Scoreboard bench for ea_pair_gen: the driver pushes expected results,
// the monitor pops and compares them on falling edges.
module ea_pair_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  src_mode = '0, dst_mode = '0;
    logic [3:0]  src_idx = '0, dst_idx = '0, ofs_idx = '0;
    logic [15:0] lit = '0;
    logic        byte_op = 1'b0;
    logic [3:0]  rd_src_addr, rd_dst_addr, rd_ofs_addr;
    logic [15:0] rd_src_data, rd_dst_data, rd_ofs_data;
    logic        out_valid, src_ea_valid, dst_ea_valid, src_wb_en, dst_wb_en;
    logic [15:0] src_ea, dst_ea, src_wb_data, dst_wb_data;
    logic [3:0]  src_wb_idx, dst_wb_idx;

    logic [15:0] rf [16];

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [15:0] sea;
        logic        seav;
        logic [15:0] dea;
        logic        deav;
        logic        swe;
        logic [3:0]  swi;
        logic [15:0] swd;
        logic        dwe;
        logic [3:0]  dwi;
        logic [15:0] dwd;
    } exp_t;

    exp_t  q[$];
    string tq[$];

    always #10 clk = ~clk;

    assign rd_src_data = rf[rd_src_addr];
    assign rd_dst_data = rf[rd_dst_addr];
    assign rd_ofs_data = rf[rd_ofs_addr];

    ea_pair_gen u_ea_pair_gen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_mode(src_mode), .src_idx(src_idx), .dst_mode(dst_mode),
        .dst_idx(dst_idx), .ofs_idx(ofs_idx), .lit(lit), .byte_op(byte_op),
        .rd_src_addr(rd_src_addr), .rd_dst_addr(rd_dst_addr), .rd_ofs_addr(rd_ofs_addr),
        .rd_src_data(rd_src_data), .rd_dst_data(rd_dst_data), .rd_ofs_data(rd_ofs_data),
        .out_valid(out_valid), .src_ea(src_ea), .src_ea_valid(src_ea_valid),
        .dst_ea(dst_ea), .dst_ea_valid(dst_ea_valid),
        .src_wb_en(src_wb_en), .src_wb_idx(src_wb_idx), .src_wb_data(src_wb_data),
        .dst_wb_en(dst_wb_en), .dst_wb_idx(dst_wb_idx), .dst_wb_data(dst_wb_data)
    );

    // Requirement model of one operand (R3-R10).
    function automatic void op_model(input logic [3:0] m, input logic [15:0] base,
                                     input logic [15:0] ofs, input logic [15:0] l,
                                     input logic b, output logic [15:0] ea,
                                     output logic eav, output logic wr,
                                     output logic [15:0] dl);
        logic [15:0] st;
        st = b ? 16'd1 : 16'd2;
        ea = '0; eav = 1'b1; wr = 1'b0; dl = '0;
        case (m)
            4'd1: ea = l;
            4'd2: ea = base;
            4'd3: begin ea = base; wr = 1'b1; dl = st; end
            4'd4: begin ea = base; wr = 1'b1; dl = 16'd0 - st; end
            4'd5: begin dl = st; ea = base + dl; wr = 1'b1; end
            4'd6: begin dl = 16'd0 - st; ea = base + dl; wr = 1'b1; end
            4'd7: ea = base + ofs;
            4'd8: ea = base + l;
            default: eav = 1'b0;
        endcase
    endfunction

    // Driver: apply one operation at a falling edge and push its expected result.
    task automatic drive(input logic [3:0] sm, input logic [3:0] si, input logic [3:0] dm,
                         input logic [3:0] di, input logic [3:0] oi, input logic [15:0] l,
                         input logic b, input string tag);
        exp_t e;
        logic [15:0] sd, dd;
        logic sw, dw;
        op_model(sm, rf[si], rf[oi], l, b, e.sea, e.seav, sw, sd);
        op_model(dm, rf[di], rf[oi], l, b, e.dea, e.deav, dw, dd);
        e.swi = si; e.dwi = di;
        e.swd = rf[si] + sd;
        e.dwd = rf[di] + dd;
        e.swe = sw; e.dwe = dw;
        if (sw && dw && si == di) begin
            e.swe = 1'b0;
            e.dwd = rf[di] + sd + dd;
        end
        @(negedge clk);
        src_mode = sm; src_idx = si; dst_mode = dm; dst_idx = di;
        ofs_idx = oi; lit = l; byte_op = b; in_valid = 1'b1;
        q.push_back(e);
        tq.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic fail_line(input string tag, input string what,
                             input logic [15:0] act, input logic [15:0] exp);
        mismatched++;
        $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    endtask

    // Monitor: compare each result with the front of the queue (R2 for idle cycles).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                compared++;
                if (q.size() == 0) begin
                    fail_line("R2", "unexpected out_valid", 16'd1, 16'd0);
                end else begin
                    exp_t e;
                    string t;
                    int bad;
                    e = q.pop_front();
                    t = tq.pop_front();
                    bad = mismatched;
                    if (src_ea_valid !== e.seav) fail_line(t, "src_ea_valid", 16'(src_ea_valid), 16'(e.seav));
                    if (e.seav && src_ea !== e.sea) fail_line(t, "src_ea", src_ea, e.sea);
                    if (dst_ea_valid !== e.deav) fail_line(t, "dst_ea_valid", 16'(dst_ea_valid), 16'(e.deav));
                    if (e.deav && dst_ea !== e.dea) fail_line(t, "dst_ea", dst_ea, e.dea);
                    if (src_wb_en !== e.swe) fail_line(t, "src_wb_en", 16'(src_wb_en), 16'(e.swe));
                    if (e.swe && (src_wb_idx !== e.swi || src_wb_data !== e.swd))
                        fail_line(t, "src_wb idx/data", {src_wb_idx, src_wb_data[11:0]}, {e.swi, e.swd[11:0]});
                    if (e.swe && src_wb_data !== e.swd) fail_line(t, "src_wb_data", src_wb_data, e.swd);
                    if (dst_wb_en !== e.dwe) fail_line(t, "dst_wb_en", 16'(dst_wb_en), 16'(e.dwe));
                    if (e.dwe && dst_wb_idx !== e.dwi) fail_line(t, "dst_wb_idx", 16'(dst_wb_idx), 16'(e.dwi));
                    if (e.dwe && dst_wb_data !== e.dwd) fail_line(t, "dst_wb_data", dst_wb_data, e.dwd);
                    if (mismatched > bad + 1) mismatched = bad + 1;
                end
            end else if (q.size() != 0 && in_valid == 1'b0) begin
                compared++;
                fail_line("R2", "missing out_valid", 16'd0, 16'd1);
                void'(q.pop_front());
                void'(tq.pop_front());
            end else if (src_wb_en || dst_wb_en) begin
                compared++;
                fail_line("R2", "writeback without out_valid", 16'({src_wb_en, dst_wb_en}), 16'd0);
            end
        end
    end

    task automatic summary;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            mismatched++;
            $display("FAIL watchdog actual=%0d expected=<50000", cycles);
            summary();
        end
    end

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < 16; i++) rf[i] = 16'h1000 + 16'(i * 16'h0111);
        rf[3]  = 16'hFFFF;
        rf[4]  = 16'h0000;
        rf[5]  = 16'h0020;
        rf[9]  = 16'hFFF0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        compared++;
        if (out_valid !== 1'b0 || src_wb_en !== 1'b0 || dst_wb_en !== 1'b0)
            fail_line("R1", "reset outputs", 16'({out_valid, src_wb_en, dst_wb_en}), 16'd0);
        rst_n = 1'b1;
        idle(2);
        // R3: register operand and unused code
        drive(4'd0, 4'd1, 4'd0, 4'd2, 4'd0, 16'h1234, 1'b0, "R3");
        drive(4'd12, 4'd1, 4'd15, 4'd2, 4'd0, 16'h1234, 1'b0, "R3");
        // R4: absolute
        drive(4'd1, 4'd1, 4'd1, 4'd2, 4'd0, 16'hBEEF, 1'b0, "R4");
        // R5: indirect
        drive(4'd2, 4'd6, 4'd2, 4'd7, 4'd0, 16'h0, 1'b0, "R5");
        idle(1);
        // R6: post modify word and byte
        drive(4'd3, 4'd6, 4'd4, 4'd7, 4'd0, 16'h0, 1'b0, "R6");
        drive(4'd4, 4'd6, 4'd3, 4'd7, 4'd0, 16'h0, 1'b1, "R6");
        // R7: pre modify
        drive(4'd5, 4'd8, 4'd6, 4'd10, 4'd0, 16'h0, 1'b1, "R7");
        drive(4'd6, 4'd8, 4'd5, 4'd10, 4'd0, 16'h0, 1'b0, "R7");
        // R8: step size and wrap at both ends
        drive(4'd5, 4'd3, 4'd4, 4'd4, 4'd0, 16'h0, 1'b0, "R8");
        drive(4'd3, 4'd3, 4'd6, 4'd4, 4'd0, 16'h0, 1'b1, "R8");
        // R9: indexed with shared offset register
        drive(4'd7, 4'd6, 4'd7, 4'd9, 4'd5, 16'h0, 1'b0, "R9");
        drive(4'd7, 4'd3, 4'd7, 4'd2, 4'd9, 16'h0, 1'b0, "R9");
        // R10: literal offset including wrap
        drive(4'd8, 4'd9, 4'd8, 4'd1, 4'd0, 16'h0030, 1'b0, "R10");
        // R11: mixed modes
        drive(4'd3, 4'd1, 4'd7, 4'd2, 4'd5, 16'h0, 1'b0, "R11");
        drive(4'd1, 4'd1, 4'd6, 4'd2, 4'd5, 16'h4000, 1'b1, "R11");
        idle(2);
        // R12: shared modified register
        drive(4'd3, 4'd5, 4'd6, 4'd5, 4'd0, 16'h0, 1'b0, "R12");
        drive(4'd5, 4'd5, 4'd5, 4'd5, 4'd0, 16'h0, 1'b1, "R12");
        drive(4'd2, 4'd5, 4'd3, 4'd5, 4'd0, 16'h0, 1'b0, "R12");
        drive(4'd4, 4'd3, 4'd3, 4'd3, 4'd0, 16'h0, 1'b0, "R12");
        idle(1);
        // R13 and R11: mixed sequence from a linear feedback register
        lf = 16'hACE1;
        for (int k = 0; k < 40; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            drive(4'(lf[3:0] % 10), lf[7:4], 4'(lf[11:8] % 10), lf[15:12],
                  lf[9:6], {lf[7:0], lf[15:8]}, lf[2], "R13");
            if (lf[0]) idle(1);
        end
        idle(3);
        compared++;
        if (q.size() != 0) fail_line("R2", "pending results", 16'(q.size()), 16'd0);
        summary();
    end
endmodule